// File: doc/BRIEF.md
# Accumulator Processor with Operand-Free Escape Opcode

This block is a small multi-cycle processor built around one accumulator. Every instruction is one 8-bit word. The upper nibble holds the opcode and the lower nibble holds a 4-bit operand. Code and data share an internal store of sixteen 8-bit words. A sequencer takes each instruction through three or four states: fetch, decode, execute, and a memory read when the instruction needs one. The datapath registers are:

- the accumulator;
- the instruction word register;
- the program counter;
- the address latch;
- the memory-data latch;
- the buffer that holds the first ALU operand;
- four condition flags, N, Z, V and C.

Opcode 15 is an escape. Under opcode 15 the low nibble does not name a memory address. It selects one of up to sixteen operations that act only on the accumulator.

A test harness loads the store through a side port while reset is held. It then releases reset and waits for the `halted` output. It reads back the accumulator, the program counter, the flags and the memory words. Reset leaves the store unchanged, so one program can run many times with new data words.

Top module: `acc_cpu`

## Requirements
- R1: Synchronous active-high reset sets the accumulator, the program counter, all four flags and `halted` to zero, and it leaves the memory contents unchanged.
- R2: Opcode 0 loads memory[operand] into the accumulator and leaves the flags unchanged. Opcode 1 writes the accumulator to memory[operand]. The preload port reads any word asynchronously and writes it on a clock edge when `pre_we` is high.
- R3: Opcode 5 adds memory[operand] to the accumulator. C receives the unsigned carry-out, V is set on signed overflow, N is set to bit 7 of the result, and Z is set when the result is zero.
- R4: Opcode 6 subtracts memory[operand] from the accumulator. C is set when a borrow occurs (the accumulator is below the operand when both are read as unsigned). V is set on signed overflow. N and Z are set from the result.
- R5: Opcode 3 (AND) and opcode 4 (OR) combine the accumulator with memory[operand]. They set N and Z from the result, clear V and keep C.
- R6: Opcode 15 selects an operand-free operation from the low nibble: 0 clears the accumulator, 4 adds 1, 5 subtracts 1 and 6 inverts every bit. Add 1 sets the flags as R3 does and subtract 1 sets them as R4 does. Clear sets Z, clears N and keeps V and C. Invert clears V and keeps C.
- R7: Sub-code 2 shifts the accumulator left by one bit and sub-code 3 shifts it right by one bit, in both cases filling with zero. The bit shifted out goes to C, N and Z are set from the result, and V is kept.
- R8: Opcode 2 jumps unconditionally to the operand address. The conditional jumps load the operand into the program counter when their condition holds and otherwise continue in sequence. The conditions are: opcode 7 when Z=1, opcode 8 when Z=0 and N=0, opcode 9 when N=1, opcode 10 when Z=0, and opcode 11 when V=1.
- R9: Sub-code 1 halts the machine. `halted` rises and stays high until reset, with the accumulator and the program counter frozen. The program counter then holds the address of the halt instruction plus one.
- R10: Opcodes 12 to 14 and escape sub-codes 7 to 15 change no register, no flag and no memory word. The program counter wraps from 15 to 0.
- R11: An instruction takes three clock cycles: fetch, decode and execute. Opcodes 0, 3, 4, 5 and 6 take one extra cycle. After reset is released, a load followed by a halt raises `halted` after exactly 7 rising edges.
- R12: The debug flag output is ordered {N, Z, V, C} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload address for reads and writes |
| pre_wdata | input | 8 | Preload write data |
| pre_rdata | output | 8 | Memory word at `pre_addr`, read asynchronously |
| halted | output | 1 | High once the halt operation has executed |
| dbg_acc | output | 8 | Accumulator |
| dbg_ip | output | 4 | Program counter |
| dbg_flags | output | 4 | Flags in the order {N, Z, V, C} |

## Verification
The bench uses the package defaults: a 4-bit address field and an 8-bit word. At this size every one of the 256 accumulator values can be run through each single-operand escape operation. The two-operand operations run over a lattice of operand pairs that includes 0x00, 0x7F, 0x80 and 0xFF, so every carry, borrow and signed-overflow boundary is covered. Each conditional jump is tried against flags produced by real additions, which makes both the taken and the not-taken paths reachable for every condition.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    parameter int ADDR_W = 4;
    parameter int OP_W   = 4;
    localparam int WORD_W = OP_W + ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MSB    = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [3:0] {
        OP_LD  = 4'h0, OP_MOV = 4'h1, OP_JMP = 4'h2, OP_AND = 4'h3,
        OP_OR  = 4'h4, OP_ADD = 4'h5, OP_SUB = 4'h6, OP_IFE = 4'h7,
        OP_IFB = 4'h8, OP_IFL = 4'h9, OP_IFN = 4'hA, OP_IFV = 4'hB,
        OP_NC  = 4'hC, OP_ND  = 4'hD, OP_NE  = 4'hE, OP_ESC = 4'hF
    } opcode_t;

    typedef enum logic [3:0] {
        ESC_CLA = 4'h0, ESC_OFF = 4'h1, ESC_LSH = 4'h2, ESC_RSH = 4'h3,
        ESC_INC = 4'h4, ESC_DEC = 4'h5, ESC_INV = 4'h6, ESC_N7  = 4'h7,
        ESC_N8  = 4'h8, ESC_N9  = 4'h9, ESC_NA  = 4'hA, ESC_NB  = 4'hB,
        ESC_NC  = 4'hC, ESC_ND  = 4'hD, ESC_NE  = 4'hE, ESC_NF  = 4'hF
    } esc_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_HALT
    } state_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_INV, ALU_SHL, ALU_SHR, ALU_CLR
    } alu_op_t;

    typedef struct packed {
        word_t  res;
        flags_t fl;
    } alu_out_t;

    // Opcodes whose execute step reads a memory operand.
    function automatic logic reads_mem(opcode_t op);
        return (op == OP_LD) || (op == OP_AND) || (op == OP_OR) ||
               (op == OP_ADD) || (op == OP_SUB);
    endfunction

    // Branch condition evaluation for the flag-testing jumps.
    function automatic logic branch_hit(opcode_t op, flags_t f);
        case (op)
            OP_IFE:  return f.z;
            OP_IFB:  return !f.z && !f.n;
            OP_IFL:  return f.n;
            OP_IFN:  return !f.z;
            OP_IFV:  return f.v;
            default: return 1'b0;
        endcase
    endfunction

    // Escape sub-codes that write the accumulator through the ALU.
    function automatic logic esc_uses_alu(esc_t s);
        return (s == ESC_CLA) || (s == ESC_LSH) || (s == ESC_RSH) ||
               (s == ESC_INC) || (s == ESC_DEC) || (s == ESC_INV);
    endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  pre_we,
    input  addr_t pre_addr,
    input  word_t pre_wdata,
    output word_t pre_rdata,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  word_t cpu_wdata,
    output word_t cpu_rdata
);
    word_t store [DEPTH];

    // Preload has priority; the harness only writes while the core is idle.
    always_ff @(posedge clk) begin
        if (pre_we)
            store[pre_addr] <= pre_wdata;
        else if (cpu_we)
            store[cpu_addr] <= cpu_wdata;
    end

    assign pre_rdata = store[pre_addr];
    assign cpu_rdata = store[cpu_addr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  alu_op_t  op,
    input  word_t    a,
    input  word_t    b,
    input  flags_t   fin,
    output alu_out_t y
);
    logic [WORD_W:0] wide;

    always_comb begin
        wide  = '0;
        y.res = '0;
        y.fl  = fin;
        case (op)
            ALU_ADD: begin
                wide    = {1'b0, a} + {1'b0, b};
                y.res   = wide[WORD_W-1:0];
                y.fl.c  = wide[WORD_W];
                y.fl.v  = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
            end
            ALU_SUB: begin
                wide    = {1'b0, a} - {1'b0, b};
                y.res   = wide[WORD_W-1:0];
                y.fl.c  = wide[WORD_W];
                y.fl.v  = (a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]);
            end
            ALU_AND: begin
                y.res  = a & b;
                y.fl.v = 1'b0;
            end
            ALU_OR: begin
                y.res  = a | b;
                y.fl.v = 1'b0;
            end
            ALU_INV: begin
                y.res  = ~a;
                y.fl.v = 1'b0;
            end
            ALU_SHL: begin
                y.res  = {a[MSB-1:0], 1'b0};
                y.fl.c = a[MSB];
            end
            ALU_SHR: begin
                y.res  = {1'b0, a[MSB:1]};
                y.fl.c = a[0];
            end
            default: y.res = '0;
        endcase
        y.fl.n = y.res[MSB];
        y.fl.z = (y.res == '0);
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  word_t    mem_rdata,
    output addr_t    mem_addr,
    output logic     mem_we,
    output word_t    mem_wdata,
    output alu_op_t  alu_op,
    output word_t    alu_a,
    output word_t    alu_b,
    input  alu_out_t alu_y,
    output word_t    acc,
    output addr_t    ip,
    output flags_t   fl,
    output logic     halted
);
    state_t  st;
    word_t   cr, dr, br;
    addr_t   ar;
    opcode_t op;
    esc_t    sub;

    assign op  = opcode_t'(cr[WORD_W-1 -: OP_W]);
    assign sub = esc_t'(cr[ADDR_W-1:0]);

    assign mem_addr  = (st == ST_FETCH) ? ip : ar;
    assign mem_we    = (st == ST_EXEC) && (op == OP_MOV);
    assign mem_wdata = acc;
    assign halted    = (st == ST_HALT);

    // Operand routing into the ALU.
    always_comb begin
        alu_op = ALU_ADD;
        alu_a  = acc;
        alu_b  = dr;
        if (st == ST_MEM) begin
            alu_a = br;
            case (op)
                OP_AND:  alu_op = ALU_AND;
                OP_OR:   alu_op = ALU_OR;
                OP_SUB:  alu_op = ALU_SUB;
                default: alu_op = ALU_ADD;
            endcase
        end else begin
            case (sub)
                ESC_CLA: alu_op = ALU_CLR;
                ESC_LSH: alu_op = ALU_SHL;
                ESC_RSH: alu_op = ALU_SHR;
                ESC_INC: begin alu_op = ALU_ADD; alu_b = word_t'(1); end
                ESC_DEC: begin alu_op = ALU_SUB; alu_b = word_t'(1); end
                ESC_INV: alu_op = ALU_INV;
                default: alu_op = ALU_CLR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_FETCH;
            acc <= '0;
            cr  <= '0;
            dr  <= '0;
            br  <= '0;
            ar  <= '0;
            ip  <= '0;
            fl  <= '0;
        end else begin
            case (st)
                ST_FETCH: begin
                    cr <= mem_rdata;
                    ar <= ip;
                    ip <= ip + addr_t'(1);
                    st <= ST_DECODE;
                end
                ST_DECODE: begin
                    ar <= cr[ADDR_W-1:0];
                    st <= ST_EXEC;
                end
                ST_EXEC: begin
                    st <= ST_FETCH;
                    if (reads_mem(op)) begin
                        dr <= mem_rdata;
                        br <= acc;
                        st <= ST_MEM;
                    end else if (op == OP_JMP) begin
                        ip <= ar;
                    end else if (branch_hit(op, fl)) begin
                        ip <= ar;
                    end else if (op == OP_ESC) begin
                        if (sub == ESC_OFF) begin
                            st <= ST_HALT;
                        end else if (esc_uses_alu(sub)) begin
                            acc <= alu_y.res;
                            fl  <= alu_y.fl;
                        end
                    end
                end
                ST_MEM: begin
                    if (op == OP_LD) begin
                        acc <= dr;
                    end else begin
                        acc <= alu_y.res;
                        fl  <= alu_y.fl;
                    end
                    st <= ST_FETCH;
                end
                default: st <= ST_HALT;
            endcase
        end
    end

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st == ST_HALT |=> st == ST_HALT && $stable(acc) && $stable(ip));

    // R10
    fetch_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        st == ST_FETCH |=> ip == addr_t'($past(ip) + addr_t'(1)));

    // R11
    ip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECODE || st == ST_MEM) |=> $stable(ip));

    // R11
    decode_next_chk: assert property (@(posedge clk) disable iff (rst)
        st == ST_DECODE |=> st == ST_EXEC);

    // R5
    logic_vclr_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MEM && (op == OP_AND || op == OP_OR)) |=> !fl.v && $stable(fl.c));

    // R2
    load_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MEM && op == OP_LD) |=> $stable(fl));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && op == OP_JMP) |=> ip == $past(cr[ADDR_W-1:0]));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_we,
    input  logic [3:0] pre_addr,
    input  logic [7:0] pre_wdata,
    output logic [7:0] pre_rdata,
    output logic       halted,
    output logic [7:0] dbg_acc,
    output logic [3:0] dbg_ip,
    output logic [3:0] dbg_flags
);
    addr_t    mem_addr;
    logic     mem_we;
    word_t    mem_wdata, mem_rdata;
    alu_op_t  alu_op;
    word_t    alu_a, alu_b;
    alu_out_t alu_y;
    word_t    acc;
    addr_t    ip;
    flags_t   fl;

    acc_cpu_mem u_mem (
        .clk       (clk),
        .pre_we    (pre_we),
        .pre_addr  (pre_addr),
        .pre_wdata (pre_wdata),
        .pre_rdata (pre_rdata),
        .cpu_we    (mem_we),
        .cpu_addr  (mem_addr),
        .cpu_wdata (mem_wdata),
        .cpu_rdata (mem_rdata)
    );

    acc_cpu_alu u_alu (
        .op  (alu_op),
        .a   (alu_a),
        .b   (alu_b),
        .fin (fl),
        .y   (alu_y)
    );

    acc_cpu_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .alu_op    (alu_op),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_y     (alu_y),
        .acc       (acc),
        .ip        (ip),
        .fl        (fl),
        .halted    (halted)
    );

    // R12: packed struct order gives {N, Z, V, C}
    assign dbg_acc   = acc;
    assign dbg_ip    = ip;
    assign dbg_flags = fl;
endmodule

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [7:0] pre_wdata = '0;
    logic [7:0] pre_rdata;
    logic       halted;
    logic [7:0] dbg_acc;
    logic [3:0] dbg_ip;
    logic [3:0] dbg_flags;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_wdata(pre_wdata), .pre_rdata(pre_rdata), .halted(halted),
        .dbg_acc(dbg_acc), .dbg_ip(dbg_ip), .dbg_flags(dbg_flags)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic poke(input logic [3:0] a, input logic [7:0] d);
        pre_we = 1'b1; pre_addr = a; pre_wdata = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        pre_addr = a;
        #1;
        d = pre_rdata;
    endtask

    task automatic run(output int cyc);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Reference ALU: sel 0 add,1 sub,2 and,3 or,4 invert,5 shl,6 shr,7 clear.
    // Returns {result, N, Z, V, C}.
    function automatic logic [11:0] ref_alu(int sel, logic [7:0] a, logic [7:0] b, logic [3:0] fin);
        int s, sa, sb;
        logic [7:0] r;
        logic n, z, v, c;
        v = fin[1]; c = fin[0];
        sa = (a > 127) ? int'(a) - 256 : int'(a);
        sb = (b > 127) ? int'(b) - 256 : int'(b);
        case (sel)
            0: begin s = int'(a) + int'(b); r = s[7:0]; c = (s > 255);
                     v = ((sa + sb) > 127) || ((sa + sb) < -128); end
            1: begin s = int'(a) - int'(b); r = s[7:0]; c = (a < b);
                     v = ((sa - sb) > 127) || ((sa - sb) < -128); end
            2: begin r = a & b; v = 1'b0; end
            3: begin r = a | b; v = 1'b0; end
            4: begin r = 8'hFF - a; v = 1'b0; end
            5: begin r = 8'((int'(a) * 2) % 256); c = (a >= 128); end
            6: begin r = 8'(int'(a) / 2); c = (a % 2 == 1); end
            default: r = 8'h00;
        endcase
        n = (r >= 128);
        z = (r == 0);
        return {r, n, z, v, c};
    endfunction

    function automatic logic [7:0] pick32(int j);
        return 8'(j * 8 + ((j % 2 == 1) ? 7 : 0));
    endfunction

    function automatic logic [7:0] pick16(int j);
        return 8'(j * 16 + ((j % 2 == 1) ? 15 : 0));
    endfunction

    initial begin
        int cyc;
        logic [7:0] m;
        logic [11:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset acc", dbg_acc, 0);
        check("R1 reset ip", dbg_ip, 0);
        check("R1 reset flags", dbg_flags, 0);
        check("R1 reset halted", halted, 0);
        for (int i = 0; i < 16; i++) poke(4'(i), 8'h00);

        // R11: LD then OFF -> 7 rising edges; R9 ip = 2
        poke(4'h0, 8'h0E); poke(4'h1, 8'hF1); poke(4'hE, 8'h9C);
        run(cyc);
        check("R11 cycle count", cyc, 7);
        check("R9 ip after halt", dbg_ip, 2);
        check("R2 load value", dbg_acc, 8'h9C);
        check("R2 load keeps flags", dbg_flags, 0);
        rst = 1'b1; @(negedge clk);
        check("R1 reset clears acc", dbg_acc, 0);
        check("R1 reset clears ip", dbg_ip, 0);
        check("R1 reset clears halted", halted, 0);
        peek(4'hE, m);
        check("R1 memory kept", m, 8'h9C);

        // R3 R4 R5 pair sweep: LD E; op F; MOV D; OFF
        poke(4'h0, 8'h0E); poke(4'h2, 8'h1D); poke(4'h3, 8'hF1);
        for (int o = 0; o < 4; o++) begin
            int nn;
            logic [3:0] opc;
            string tag;
            opc = (o == 0) ? 4'h5 : (o == 1) ? 4'h6 : (o == 2) ? 4'h3 : 4'h4;
            tag = (o == 0) ? "R3 add" : (o == 1) ? "R4 sub" : "R5 logic";
            nn  = (o < 2) ? 32 : 16;
            poke(4'h1, {opc, 4'hF});
            for (int i = 0; i < nn; i++) begin
                for (int j = 0; j < nn; j++) begin
                    logic [7:0] a, b;
                    a = (nn == 32) ? pick32(i) : pick16(i);
                    b = (nn == 32) ? pick32(j) : pick16(j);
                    poke(4'hE, a); poke(4'hF, b);
                    run(cyc);
                    r = ref_alu(o, a, b, 4'h0);
                    check(tag, {dbg_acc, dbg_flags}, r);
                    peek(4'hD, m);
                    check("R2 store", m, r[11:4]);
                end
            end
        end

        // R6 R7 R12: escape sweep over every accumulator value
        poke(4'h2, 8'hF1);
        for (int k = 0; k < 6; k++) begin
            logic [3:0] sc;
            int sel;
            logic [7:0] bb;
            string tag;
            sc  = (k == 0) ? 4'h0 : (k == 1) ? 4'h2 : (k == 2) ? 4'h3 :
                  (k == 3) ? 4'h4 : (k == 4) ? 4'h5 : 4'h6;
            sel = (k == 0) ? 7 : (k == 1) ? 5 : (k == 2) ? 6 : (k == 3) ? 0 : (k == 4) ? 1 : 4;
            tag = (k == 1 || k == 2) ? "R7 shift" : "R6 escape R12";
            bb  = 8'h01;
            poke(4'h1, {4'hF, sc});
            for (int a = 0; a < 256; a++) begin
                poke(4'hE, 8'(a));
                run(cyc);
                check(tag, {dbg_acc, dbg_flags}, ref_alu(sel, 8'(a), bb, 4'h0));
            end
        end

        // R8: conditional jumps after ADD
        poke(4'h0, 8'h0E); poke(4'h1, 8'h5F); poke(4'h3, 8'h0B); poke(4'h4, 8'hF1);
        poke(4'h5, 8'h0C); poke(4'h6, 8'hF1); poke(4'hB, 8'h11); poke(4'hC, 8'h22);
        for (int cnd = 7; cnd <= 11; cnd++) begin
            poke(4'h2, {4'(cnd), 4'h5});
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    logic tk;
                    poke(4'hE, pick16(i)); poke(4'hF, pick16(j));
                    run(cyc);
                    r = ref_alu(0, pick16(i), pick16(j), 4'h0);
                    case (cnd)
                        7:  tk = r[2];
                        8:  tk = !r[2] && !r[3];
                        9:  tk = r[3];
                        10: tk = !r[2];
                        default: tk = r[1];
                    endcase
                    check("R8 branch result", {dbg_acc, dbg_flags}, {(tk ? 8'h22 : 8'h11), r[3:0]});
                    check("R8 branch ip", dbg_ip, tk ? 7 : 5);
                end
            end
        end

        // R8: unconditional jump
        poke(4'h0, 8'h25); poke(4'h1, 8'h0B); poke(4'h2, 8'hF1);
        run(cyc);
        check("R8 jmp", dbg_acc, 8'h22);
        check("R8 jmp ip", dbg_ip, 7);

        // R10: unused opcodes and sub-codes
        poke(4'h0, 8'h0E); poke(4'h1, 8'hCD); poke(4'h2, 8'hDD); poke(4'h3, 8'hED);
        poke(4'h4, 8'hF7); poke(4'h5, 8'hFF); poke(4'h6, 8'hF1);
        poke(4'hD, 8'h5A); poke(4'hE, 8'h3C);
        run(cyc);
        check("R10 nop acc", dbg_acc, 8'h3C);
        check("R10 nop flags", dbg_flags, 0);
        check("R10 nop ip", dbg_ip, 7);
        peek(4'hD, m);
        check("R10 nop memory", m, 8'h5A);

        // R10 wrap and R9 sticky halt
        poke(4'h0, 8'h72); poke(4'h1, 8'h2E); poke(4'h2, 8'hF1);
        poke(4'hE, 8'hF0); poke(4'hF, 8'hF9);
        run(cyc);
        check("R10 wrap ip", dbg_ip, 3);
        check("R10 wrap flags", {dbg_acc, dbg_flags}, {8'h00, 4'b0100});
        repeat (10) @(negedge clk);
        check("R9 stays halted", {halted, dbg_acc, dbg_ip}, {1'b1, 8'h00, 4'h3});

        // R5: logic keeps C and clears V
        poke(4'h0, 8'h0E); poke(4'h1, 8'hF2); poke(4'h2, 8'h4F); poke(4'h3, 8'hF1);
        poke(4'hE, 8'h80); poke(4'hF, 8'h0F);
        run(cyc);
        check("R5 or keeps C", {dbg_acc, dbg_flags}, {8'h0F, 4'b0001});
        poke(4'h1, 8'hF4); poke(4'h2, 8'h3F);
        poke(4'hE, 8'h7F); poke(4'hF, 8'hFF);
        run(cyc);
        check("R5 and clears V", {dbg_acc, dbg_flags}, {8'h80, 4'b1000});

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule